// File: doc/BRIEF.md
# Dual-Mode Priority Interrupt Controller

The controller gathers edge-type requests from a set of peripheral sources and from two unmaskable sources: an emergency interrupt and a wake-from-sleep interrupt. It picks the single most urgent eligible request and shows it to the CPU as a request line with a vector number. The CPU takes the request at an instruction boundary. In that same cycle a save strobe stands for stacking the return address and status, the pending flag of the taken source is cleared, and the mask state is updated.

A mode input picks one of two schemes at run time. In fixed mode, source order sets priority and one global mask bit holds back every maskable source. In level mode, each source has a programmable 3-bit level, and a 3-bit mask level gates the sources. In both modes the two unmaskable sources ignore all masks. A mask-load port lets the CPU restore its mask state, for example on return from a handler.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_req_o=0, save_o=0, gmask_o=1 and lvl_mask_o=7.
- R2: A rising edge on a request input sets that source's pending flag at the sampling clock edge. irq_req_o reflects it after that edge. The flag stays set after the input falls, until the source is accepted.
- R3: A pending source whose src_en_i bit is 0 takes no part in arbitration but keeps its pending flag. It competes again once its enable bit is 1.
- R4: In fixed mode (mode_i=0), the lowest-numbered eligible source wins. Source i gets vector 64+i.
- R5: In fixed mode with gmask_o=1, no peripheral source is requested. The emergency and wake sources still are.
- R6: A request is accepted only in a cycle with irq_req_o=1 and boundary_i=1. save_o is 1 in exactly that cycle. Only the accepted source's pending flag is cleared, and the others remain pending.
- R7: In the cycle after any acceptance, gmask_o=1, in either mode.
- R8: In level mode (mode_i=1), a peripheral source is eligible only if its level is strictly greater than lvl_mask_o. gmask_o has no effect in this mode.
- R9: In level mode, the highest level wins. Among equal levels, the lower source index wins.
- R10: In level mode, acceptance loads lvl_mask_o with the accepted source's level. The emergency source loads 7. The wake source leaves lvl_mask_o unchanged. In fixed mode, lvl_mask_o is unchanged by acceptance.
- R11: The emergency source (vector 7) beats the wake source (vector 8). Both beat every peripheral source.
- R12: mask_ld_i=1 loads gmask_o and lvl_mask_o from mask_gm_i and mask_lvl_i at the next edge. If an acceptance happens in the same cycle, the acceptance update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = fixed order with global mask bit, 1 = programmable levels with level mask |
| src_req_i | input | N_SRC | Peripheral request lines, rising-edge sensitive |
| src_en_i | input | N_SRC | Per-source enable |
| src_lvl_i | input | N_SRC*3 | Per-source level, source i in bits [3i+2:3i] |
| nmi_i | input | 1 | Unmaskable emergency request, rising-edge sensitive |
| wake_i | input | 1 | Unmaskable wake-from-sleep request, rising-edge sensitive |
| boundary_i | input | 1 | CPU is at an instruction boundary and may accept |
| mask_ld_i | input | 1 | Load the mask state |
| mask_gm_i | input | 1 | Global mask bit value to load |
| mask_lvl_i | input | 3 | Mask level value to load |
| irq_req_o | output | 1 | A request is presented to the CPU |
| irq_vec_o | output | 8 | Vector number of the presented request |
| save_o | output | 1 | Acceptance strobe, standing for the context save |
| gmask_o | output | 1 | Current global mask bit |
| lvl_mask_o | output | 3 | Current mask level |

## Verification
A request edge is registered once, so irq_req_o and irq_vec_o are valid from the first clock edge after the edge is sampled. The bench raises an input at a falling edge and reads the outputs at the next falling edge. save_o depends combinationally on boundary_i, so it is read shortly after boundary_i is driven, still inside the same cycle. Mask loads and the mask updates caused by acceptance appear one edge later, and the bench reads them at the falling edge that follows.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic MODE_FIXED = 1'b0;
  localparam logic MODE_LEVEL = 1'b1;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_NMI  = 2'd1,
    SEL_WAKE = 2'd2
  } sel_kind_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[g] <= 1'b0;
        pend_q    <= 1'b0;
      end else begin
        prev_q[g] <= req_i[g];
        // a fresh edge wins over a clear in the same cycle
        pend_q    <= (pend_q & ~clr_i[g]) | (req_i[g] & ~prev_q[g]);
      end
    end
    assign pend_o[g] = pend_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   mode_i,
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC-1:0]       en_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  input  logic                   gmask_i,
  input  logic [LVL_W-1:0]       lvl_mask_i,
  input  logic                   nmi_pend_i,
  input  logic                   wake_pend_i,
  output logic                   valid_o,
  output sel_kind_e              kind_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [LVL_W-1:0]       lvl_o
);
  logic [LVL_W-1:0] lvl_a [N_SRC];
  logic [N_SRC-1:0] elig;
  logic [LVL_W-1:0] best;
  logic             found;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign lvl_a[g] = lvl_i[g*LVL_W +: LVL_W];
    assign elig[g]  = pend_i[g] & en_i[g] &
                      ((mode_i == MODE_LEVEL) ? (lvl_a[g] > lvl_mask_i) : !gmask_i);
  end

  always_comb begin
    logic [LVL_W-1:0] key;
    found  = 1'b0;
    best   = '0;
    idx_o  = '0;
    lvl_o  = '0;
    kind_o = SEL_SRC;
    for (int i = 0; i < N_SRC; i++) begin
      // fixed mode: all keys equal, so scan order decides
      key = (mode_i == MODE_LEVEL) ? lvl_a[i] : '0;
      if (elig[i] && (!found || key > best)) begin
        found = 1'b1;
        best  = key;
        idx_o = IDX_W'(i);
        lvl_o = lvl_a[i];
      end
    end
    valid_o = found;
    if (wake_pend_i) begin
      valid_o = 1'b1;
      kind_o  = SEL_WAKE;
    end
    if (nmi_pend_i) begin
      valid_o = 1'b1;
      kind_o  = SEL_NMI;
    end
  end
endmodule

// File: rtl/irq_mask_state.sv
module irq_mask_state
  import irq_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             accept_i,
  input  sel_kind_e        kind_i,
  input  logic [LVL_W-1:0] acc_lvl_i,
  input  logic             ld_i,
  input  logic             ld_gm_i,
  input  logic [LVL_W-1:0] ld_lvl_i,
  output logic             gmask_o,
  output logic [LVL_W-1:0] lvl_mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gmask_o    <= 1'b1;
      lvl_mask_o <= '1;
    end else if (accept_i) begin
      gmask_o <= 1'b1;
      if (mode_i == MODE_LEVEL) begin
        if (kind_i == SEL_NMI)      lvl_mask_o <= '1;
        else if (kind_i == SEL_SRC) lvl_mask_o <= acc_lvl_i;
      end
    end else if (ld_i) begin
      gmask_o    <= ld_gm_i;
      lvl_mask_o <= ld_lvl_i;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int NMI_VEC  = 7,
  parameter int WAKE_VEC = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic [N_SRC-1:0]       src_req_i,
  input  logic [N_SRC-1:0]       src_en_i,
  input  logic [N_SRC*LVL_W-1:0] src_lvl_i,
  input  logic                   nmi_i,
  input  logic                   wake_i,
  input  logic                   boundary_i,
  input  logic                   mask_ld_i,
  input  logic                   mask_gm_i,
  input  logic [LVL_W-1:0]       mask_lvl_i,
  output logic                   irq_req_o,
  output logic [VEC_W-1:0]       irq_vec_o,
  output logic                   save_o,
  output logic                   gmask_o,
  output logic [LVL_W-1:0]       lvl_mask_o
);
  localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int BANK_W = N_SRC + 2;
  localparam int NMI_B  = N_SRC;
  localparam int WAKE_B = N_SRC + 1;

  logic [BANK_W-1:0] bank_req, bank_clr, pend;
  logic              valid, accept;
  sel_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [LVL_W-1:0]  sel_lvl;

  assign bank_req = {wake_i, nmi_i, src_req_i};

  irq_pend_bank #(.W(BANK_W)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (bank_req),
    .clr_i  (bank_clr),
    .pend_o (pend)
  );

  irq_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .mode_i      (mode_i),
    .pend_i      (pend[N_SRC-1:0]),
    .en_i        (src_en_i),
    .lvl_i       (src_lvl_i),
    .gmask_i     (gmask_o),
    .lvl_mask_i  (lvl_mask_o),
    .nmi_pend_i  (pend[NMI_B]),
    .wake_pend_i (pend[WAKE_B]),
    .valid_o     (valid),
    .kind_o      (kind),
    .idx_o       (idx),
    .lvl_o       (sel_lvl)
  );

  assign accept = valid & boundary_i;

  always_comb begin
    bank_clr = '0;
    if (accept) begin
      unique case (kind)
        SEL_NMI:  bank_clr[NMI_B]  = 1'b1;
        SEL_WAKE: bank_clr[WAKE_B] = 1'b1;
        default:  bank_clr[idx]    = 1'b1;
      endcase
    end
  end

  always_comb begin
    unique case (kind)
      SEL_NMI:  irq_vec_o = VEC_W'(NMI_VEC);
      SEL_WAKE: irq_vec_o = VEC_W'(WAKE_VEC);
      default:  irq_vec_o = VEC_W'(VEC_BASE) + VEC_W'(idx);
    endcase
  end

  irq_mask_state #(.LVL_W(LVL_W)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .accept_i   (accept),
    .kind_i     (kind),
    .acc_lvl_i  (sel_lvl),
    .ld_i       (mask_ld_i),
    .ld_gm_i    (mask_gm_i),
    .ld_lvl_i   (mask_lvl_i),
    .gmask_o    (gmask_o),
    .lvl_mask_o (lvl_mask_o)
  );

  assign irq_req_o = valid;
  assign save_o    = accept;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_SRC    = 8,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int NMI_VEC  = 7,
  parameter int WAKE_VEC = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   mode_i,
  input logic [N_SRC-1:0]       src_en_i,
  input logic [N_SRC*LVL_W-1:0] src_lvl_i,
  input logic                   boundary_i,
  input logic                   mask_ld_i,
  input logic                   irq_req_o,
  input logic [VEC_W-1:0]       irq_vec_o,
  input logic                   save_o,
  input logic                   gmask_o,
  input logic [LVL_W-1:0]       lvl_mask_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [VEC_W-1:0] off;
  logic             is_src;
  logic [LVL_W-1:0] cur_lvl;

  assign off     = irq_vec_o - VEC_W'(VEC_BASE);
  assign is_src  = (off < VEC_W'(N_SRC));
  assign cur_lvl = src_lvl_i[off[IDX_W-1:0]*LVL_W +: LVL_W];

  // R6: a request waiting for a boundary is not dropped while config is steady
  p_req_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && !boundary_i && !mask_ld_i |=>
      irq_req_o || !$stable(mode_i) || !$stable(src_en_i) || !$stable(src_lvl_i));

  p_gmask_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |=> gmask_o);

  p_fixed_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i && gmask_o && irq_req_o |->
      (irq_vec_o == VEC_W'(NMI_VEC)) || (irq_vec_o == VEC_W'(WAKE_VEC)));

  p_level_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i && irq_req_o && is_src |-> cur_lvl > lvl_mask_o);

  p_nmi_lvl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o && mode_i && (irq_vec_o == VEC_W'(NMI_VEC)) |=> lvl_mask_o == '1);

  p_src_lvl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o && mode_i && is_src |=> lvl_mask_o == $past(cur_lvl));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .N_SRC(N_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W),
  .VEC_BASE(VEC_BASE), .NMI_VEC(NMI_VEC), .WAKE_VEC(WAKE_VEC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .src_en_i   (src_en_i),
  .src_lvl_i  (src_lvl_i),
  .boundary_i (boundary_i),
  .mask_ld_i  (mask_ld_i),
  .irq_req_o  (irq_req_o),
  .irq_vec_o  (irq_vec_o),
  .save_o     (save_o),
  .gmask_o    (gmask_o),
  .lvl_mask_o (lvl_mask_o)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic [N-1:0] src_req_i = '0;
  logic [N-1:0] src_en_i = '1;
  logic [N*3-1:0] src_lvl_i = '0;
  logic        nmi_i = 1'b0, wake_i = 1'b0, boundary_i = 1'b0;
  logic        mask_ld_i = 1'b0, mask_gm_i = 1'b0;
  logic [2:0]  mask_lvl_i = '0;
  logic        irq_req_o, save_o, gmask_o;
  logic [7:0]  irq_vec_o;
  logic [2:0]  lvl_mask_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  prio_irq_ctrl u_dut (.*);

  typedef struct packed {
    logic        md;
    logic [7:0]  en;
    logic [23:0] lv;
    logic [9:0]  rs;   // [7:0] sources, [8] emergency, [9] wake
    logic        gm;
    logic [2:0]  ml;
    logic        er;
    logic [7:0]  ev;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'hFF, 24'h000000, 10'h028, 1'b0, 3'd0, 1'b1, 8'd67}, // R4
    '{1'b0, 8'hFF, 24'h000000, 10'h042, 1'b0, 3'd0, 1'b1, 8'd65}, // R4
    '{1'b0, 8'hFF, 24'h000000, 10'h001, 1'b1, 3'd0, 1'b0, 8'd0 }, // R5
    '{1'b0, 8'hFF, 24'h000000, 10'h201, 1'b1, 3'd0, 1'b1, 8'd8 }, // R5
    '{1'b0, 8'hFF, 24'h000000, 10'h300, 1'b1, 3'd0, 1'b1, 8'd7 }, // R11
    '{1'b0, 8'hF7, 24'h000000, 10'h018, 1'b0, 3'd0, 1'b1, 8'd68}, // R3
    '{1'b0, 8'h00, 24'h000000, 10'h004, 1'b0, 3'd0, 1'b0, 8'd0 }, // R3
    '{1'b1, 8'hFF, 24'h030018, 10'h022, 1'b0, 3'd0, 1'b1, 8'd69}, // R9
    '{1'b1, 8'hFF, 24'h100100, 10'h044, 1'b0, 3'd2, 1'b1, 8'd66}, // R9 tie
    '{1'b1, 8'hFF, 24'h000400, 10'h008, 1'b0, 3'd2, 1'b0, 8'd0 }, // R8 equal
    '{1'b1, 8'hFF, 24'h000600, 10'h008, 1'b0, 3'd2, 1'b1, 8'd67}, // R8 above
    '{1'b1, 8'hFF, 24'h000000, 10'h001, 1'b0, 3'd0, 1'b0, 8'd0 }, // R8 level 0
    '{1'b1, 8'hFF, 24'hE00000, 10'h280, 1'b0, 3'd6, 1'b1, 8'd8 }, // R11
    '{1'b1, 8'hFF, 24'h005000, 10'h010, 1'b1, 3'd0, 1'b1, 8'd68}  // R8 gm ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; src_req_i = '0; nmi_i = 0; wake_i = 0;
    boundary_i = 0; mask_ld_i = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic raise(input logic [9:0] rs);
    src_req_i = rs[7:0]; nmi_i = rs[8]; wake_i = rs[9];
    @(negedge clk_i);
    src_req_i = '0; nmi_i = 0; wake_i = 0;
  endtask

  task automatic load_mask(input logic gm, input logic [2:0] ml);
    mask_ld_i = 1'b1; mask_gm_i = gm; mask_lvl_i = ml;
    @(negedge clk_i);
    mask_ld_i = 1'b0;
  endtask

  task automatic accept_now();
    boundary_i = 1'b1;
    #1;
    chk("R6 save strobe", 32'(save_o), 1);
  endtask

  task automatic accept_end();
    @(negedge clk_i);
    boundary_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 req", 32'(irq_req_o), 0);
    chk("R1 save", 32'(save_o), 0);
    chk("R1 gmask", 32'(gmask_o), 1);
    chk("R1 lvl", 32'(lvl_mask_o), 7);

    for (int k = 0; k < NV; k++) begin
      do_reset();
      mode_i = TBL[k].md; src_en_i = TBL[k].en; src_lvl_i = TBL[k].lv;
      load_mask(TBL[k].gm, TBL[k].ml);
      raise(TBL[k].rs);
      chk($sformatf("R4/R5/R8/R9/R11 req row %0d", k), 32'(irq_req_o), 32'(TBL[k].er));
      if (TBL[k].er)
        chk($sformatf("R4/R9/R11 vec row %0d", k), 32'(irq_vec_o), 32'(TBL[k].ev));
    end

    // R2 / R6 / R7 / R12 in fixed mode
    do_reset();
    mode_i = 0; src_en_i = '1; src_lvl_i = '0;
    load_mask(1'b0, 3'd0);
    chk("R12 gmask loaded", 32'(gmask_o), 0);
    raise(10'h024);
    for (int c = 0; c < 3; c++) begin
      chk("R2 pending held req", 32'(irq_req_o), 1);
      chk("R6 no accept without boundary", 32'(save_o), 0);
      @(negedge clk_i);
    end
    chk("R4 vec src2", 32'(irq_vec_o), 66);
    accept_now();
    accept_end();
    chk("R7 gmask after accept", 32'(gmask_o), 1);
    chk("R5 masked after accept", 32'(irq_req_o), 0);
    chk("R10 fixed lvl unchanged", 32'(lvl_mask_o), 0);
    load_mask(1'b0, 3'd0);
    chk("R6 other still pending", 32'(irq_req_o), 1);
    chk("R6 other vec", 32'(irq_vec_o), 69);
    accept_now();
    accept_end();
    load_mask(1'b0, 3'd0);
    chk("R6 cleared after accept", 32'(irq_req_o), 0);

    // R12: accept wins over a same-cycle load
    raise(10'h001);
    mask_ld_i = 1'b1; mask_gm_i = 1'b0; mask_lvl_i = 3'd2;
    accept_now();
    accept_end();
    mask_ld_i = 1'b0;
    chk("R12 accept wins gmask", 32'(gmask_o), 1);
    chk("R12 accept wins lvl", 32'(lvl_mask_o), 0);

    // R3: disabled pending retained, then enabled
    load_mask(1'b0, 3'd0);
    src_en_i = 8'hF7;
    raise(10'h008);
    chk("R3 disabled no req", 32'(irq_req_o), 0);
    @(negedge clk_i);
    src_en_i = '1;
    #1;
    chk("R3 enabled req", 32'(irq_req_o), 1);
    chk("R3 enabled vec", 32'(irq_vec_o), 67);

    // R10 level mode mask updates
    do_reset();
    mode_i = 1; src_en_i = '1; src_lvl_i = 24'h005000;
    load_mask(1'b0, 3'd0);
    raise(10'h010);
    chk("R8 lvl5 over mask0", 32'(irq_vec_o), 68);
    accept_now();
    accept_end();
    chk("R10 lvl loaded", 32'(lvl_mask_o), 5);
    raise(10'h100);
    chk("R11 nmi vec", 32'(irq_vec_o), 7);
    accept_now();
    accept_end();
    chk("R10 nmi lvl7", 32'(lvl_mask_o), 7);
    load_mask(1'b0, 3'd3);
    raise(10'h200);
    chk("R11 wake vec", 32'(irq_vec_o), 8);
    accept_now();
    accept_end();
    chk("R10 wake keeps lvl", 32'(lvl_mask_o), 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule